// File: doc/BRIEF.md
# Write-in-progress status readback

This block sits on the read path of a byte-wide non-volatile memory, between the array output and the data bus. While the internal write engine reports that a program cycle is running, a read does not return stored data. It returns a status byte instead, so a host can poll for completion. Once the engine drops its busy flag, reads return array data again.

The status byte carries two independent completion indicators:

- The top bit is the complement of the top bit of the last byte the host loaded. The host keeps reading until that bit matches what it wrote.
- The next bit flips once per read access while the cycle runs. Two reads that return the same value mean the cycle has finished.

A read access is CE low, OE low and WE high. All three strobes are active-low and sampled on the clock. A new access is counted when that condition goes from false to true, whichever of the strobes brought it there. Outside an access the bus is not driven, and the data lines are held at zero. The host should keep its address fixed while polling; the block itself has no address input.

Top module: `wip_status_readback`

## Requirements
- R1: During and right after a synchronous active-low reset, `dq_drive` is 0 and `dq_out` is 0.
- R2: `dq_drive` is 1 in the cycle after the strobes read `ce_n`=0, `oe_n`=0, `we_n`=1. For the other seven strobe combinations it is 0 in the cycle after.
- R3: While `wr_busy` is 1, a read drives bit 7 of `dq_out` as the inverse of bit 7 of `last_byte`.
- R4: The first read access after `wr_busy` rises shows bit 6 as 1.
- R5: While busy, each later read access start inverts bit 6 relative to the previous access. Bit 6 holds steady for as long as one access lasts.
- R6: While busy, bits 5 to 0 of `dq_out` read as 0 during a read.
- R7: While `wr_busy` is 0, a read returns `arr_data` one cycle later.
- R8: After `wr_busy` falls, reads return array data and the toggle state no longer moves. The next rise of `wr_busy` again gives 1 on its first read.
- R9: If `wr_busy` rises in the same cycle an access starts, or while an access is already running, that access counts as the first. It shows bit 6 as 1, and the next access shows 0.
- R10: While `dq_drive` is 0, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_busy | input | 1 | Internal write cycle in progress, from the write engine |
| last_byte | input | 8 | Last data byte loaded by the host, from the write engine |
| arr_data | input | 8 | Data read from the array |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dq_out | output | 8 | Data presented to the bus |
| dq_drive | output | 1 | Bus drive enable; high during a read access |

## Verification
Two events can land on the same clock edge: the start of a write cycle (the toggle state reloads to 1) and the start of a read access (the toggle state steps). The bench provokes this in two ways.

- It raises `wr_busy` on the same edge where CE and OE go active.
- It raises `wr_busy` in the middle of a read that was already returning array data.

Both cases are judged by bit 6 of the access that overlaps the rise, which must read 1, and of the following access, which must read 0. Around these cases the bench runs long polling trains under busy. Accesses alternate between CE-driven and OE-driven starts, and each access is held for two cycles. Bit 6 must stay put within an access and flip between accesses.

// File: rtl/wip_pkg.sv
// Package: shared types for the write-in-progress status readback block.
// Assumes: one clock domain, all strobes already synchronous to it.
package wip_pkg;

    // Read access events derived from the bus strobes.
    typedef struct packed {
        logic act;    // access condition true in this cycle
        logic start;  // access condition became true in this cycle
    } rd_evt_t;

endpackage

// File: rtl/wip_strobe_decode.sv
// Module: wip_strobe_decode
// Decodes the active-low bus strobes into a read-active level and a
// one-cycle read-start event (inactive to active transition).
// Assumes: strobes are synchronous to clk and free of glitches.
module wip_strobe_decode
    import wip_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    output rd_evt_t rd_evt
);

    logic rd_now;
    logic rd_q;

    // Read access: chip enabled, output enabled, write enable released.
    always_comb begin
        rd_now = !ce_n && !oe_n && we_n;
    end

    // Remember last cycle's access level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd_now;
        end
    end

    // Publish level and start event.
    always_comb begin
        rd_evt.act   = rd_now;
        rd_evt.start = rd_now && !rd_q;
    end

    // A start event never repeats in back-to-back cycles.
    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt.start |=> !rd_evt.start);

endmodule

// File: rtl/wip_toggle_track.sv
// Module: wip_toggle_track
// Keeps the toggling status bit. It reloads to 1 when a write cycle
// begins and steps once per read access start while busy. The access
// that overlaps the busy rise counts as the first one.
// Assumes: busy comes from the write engine, synchronous to clk.
module wip_toggle_track
    import wip_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    busy,
    input  rd_evt_t rd_evt,
    output logic    tgl_view
);

    logic busy_q;
    logic busy_rise;
    logic tgl;
    logic tgl_n;
    logic fresh;
    logic fresh_n;

    // Detect the start of a new internal write cycle.
    always_comb begin
        busy_rise = busy && !busy_q;
    end

    // Next toggle and first-read flag values.
    always_comb begin
        tgl_n   = tgl;
        fresh_n = fresh;
        if (busy_rise) begin
            tgl_n   = 1'b1;
            fresh_n = !rd_evt.act;
        end else if (busy && rd_evt.start) begin
            if (fresh) begin
                fresh_n = 1'b0;
            end else begin
                tgl_n = !tgl;
            end
        end
    end

    // State registers for busy history, toggle bit and first-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tgl    <= 1'b1;
            fresh  <= 1'b1;
        end else begin
            busy_q <= busy;
            tgl    <= tgl_n;
            fresh  <= fresh_n;
        end
    end

    // Value shown by the output stage in this cycle.
    always_comb begin
        tgl_view = tgl_n;
    end

    // A new write cycle always leaves the toggle at 1.
    p_reload_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_q) |=> tgl);

    // Without a busy rise or a busy access start, the toggle stays put.
    p_toggle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(busy && !busy_q) && !(busy && rd_evt.start)) |=> $stable(tgl));

endmodule

// File: rtl/wip_status_mux.sv
// Module: wip_status_mux
// Output stage. It registers either the status byte (while busy) or the
// array data (while idle), and zeros outside a read access.
// Assumes: POLL_BIT and TGL_BIT are distinct and inside DATA_W.
module wip_status_mux
    import wip_pkg::*;
#(
    parameter int   DATA_W   = 8,
    parameter int   POLL_BIT = DATA_W - 1,
    parameter int   TGL_BIT  = DATA_W - 2,
    parameter logic FILL     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] arr_data,
    input  rd_evt_t           rd_evt,
    input  logic              tgl_view,
    output logic [DATA_W-1:0] dq,
    output logic              dq_en
);

    logic [DATA_W-1:0] status;

    // Build the status byte bit by bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_stat
        if (b == POLL_BIT) begin : g_poll
            assign status[b] = !last_byte[b];
        end else if (b == TGL_BIT) begin : g_tgl
            assign status[b] = tgl_view;
        end else begin : g_fill
            assign status[b] = FILL;
        end
    end

    // Register the bus value and its drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq    <= '0;
            dq_en <= 1'b0;
        end else begin
            dq_en <= rd_evt.act;
            if (!rd_evt.act) begin
                dq <= '0;
            end else if (busy) begin
                dq <= status;
            end else begin
                dq <= arr_data;
            end
        end
    end

    p_drive_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt.act |=> dq_en);

    p_poll_inverts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt.act && busy) |=> (dq[POLL_BIT] == !$past(last_byte[POLL_BIT])));

    p_array_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt.act && !busy) |=> (dq == $past(arr_data)));

    p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_en |-> (dq == '0));

endmodule

// File: rtl/wip_status_readback.sv
// Module: wip_status_readback (top)
// Substitutes a completion status byte for array data on reads while an
// internal write cycle runs: an inverted copy of the last loaded top bit
// and a bit that flips per read access.
// Assumes: the write engine supplies busy and last_byte; all inputs are
// synchronous to clk.
module wip_status_readback
    import wip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TGL_BIT  = DATA_W - 2;

    rd_evt_t rd_evt;
    logic    tgl_view;

    wip_strobe_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .rd_evt (rd_evt)
    );

    wip_toggle_track u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (wr_busy),
        .rd_evt   (rd_evt),
        .tgl_view (tgl_view)
    );

    wip_status_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TGL_BIT  (TGL_BIT),
        .FILL     (1'b0)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (wr_busy),
        .last_byte (last_byte),
        .arr_data  (arr_data),
        .rd_evt    (rd_evt),
        .tgl_view  (tgl_view),
        .dq        (dq_out),
        .dq_en     (dq_drive)
    );

    // Busy reads keep the filler bits at zero.
    p_fill_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && wr_busy) |=> (dq_out[TGL_BIT-1:0] == '0));

endmodule

// File: tb/tb_wip_status_readback.sv
`timescale 1ns/1ps
module tb_wip_status_readback;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_busy;
    logic [7:0] last_byte;
    logic [7:0] arr_data;
    logic       ce_n, oe_n, we_n;
    logic [7:0] dq_out;
    logic       dq_drive;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = !clk;

    wip_status_readback dut (
        .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy), .last_byte(last_byte),
        .arr_data(arr_data), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        step();
        chk("R10 idle", {dq_drive, dq_out}, 9'h000);
    endtask

    // One busy access of two cycles, started by CE (use_ce) or OE.
    task automatic busy_read(input bit use_ce, input logic t_exp, input string req);
        logic [8:0] e;
        if (use_ce) begin oe_n = 1'b0; step(); ce_n = 1'b0; end
        else begin ce_n = 1'b0; step(); oe_n = 1'b0; end
        we_n = 1'b1;
        step();
        e = {1'b1, !last_byte[7], t_exp, 6'b0};
        chk(req, {dq_drive, dq_out}, e);
        last_byte = last_byte ^ 8'h80;
        step();
        e = {1'b1, !last_byte[7], t_exp, 6'b0};
        chk("R5 R3 hold within access", {dq_drive, dq_out}, e);
        idle();
    endtask

    initial begin
        rst_n = 1'b0; wr_busy = 1'b0; last_byte = 8'h00; arr_data = 8'h00;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (3) step();
        chk("R1 reset", {dq_drive, dq_out}, 9'h000);
        ce_n = 1'b0; oe_n = 1'b0; arr_data = 8'hC3;
        step();
        chk("R1 reset with strobes", {dq_drive, dq_out}, 9'h000);
        rst_n = 1'b1;
        idle();

        // R2 and R10: every strobe combination, idle state
        for (int k = 0; k < 8; k++) begin
            logic exp_on;
            {ce_n, oe_n, we_n} = k[2:0];
            arr_data = 8'h5A ^ k[7:0];
            exp_on = (k == 1);
            step();
            chk("R2 strobe decode", {8'h00, dq_drive}, {8'h00, exp_on});
            chk("R10 R7 data", {1'b0, dq_out}, {1'b0, exp_on ? arr_data : 8'h00});
            idle();
        end

        // R7: array data sweep while idle
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        for (int v = 0; v < 256; v++) begin
            arr_data = v[7:0];
            step();
            chk("R7 array pass", {dq_drive, dq_out}, {1'b1, v[7:0]});
        end
        idle();

        // R3 R4 R5 R6 R8: several write cycles with polling trains
        for (int w = 0; w < 4; w++) begin
            logic t;
            last_byte = 8'h2B + 8'(w * 8'h61);
            arr_data  = 8'h90 + 8'(w);
            wr_busy = 1'b1;
            idle();
            t = 1'b1;
            for (int r = 0; r < 5; r++) begin
                busy_read(r[0], t, (r == 0) ? "R4 first read" : "R5 R6 toggle step");
                t = !t;
            end
            wr_busy = 1'b0;
            idle();
            ce_n = 1'b0; oe_n = 1'b0;
            step();
            chk("R8 data after busy", {dq_drive, dq_out}, {1'b1, arr_data});
            idle();
            ce_n = 1'b0; oe_n = 1'b0;
            step();
            chk("R8 second read after busy", {dq_drive, dq_out}, {1'b1, arr_data});
            idle();
        end

        // R9 case A: busy rise on the same edge as an access start
        last_byte = 8'h00;
        wr_busy = 1'b1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        step();
        chk("R9 coincident rise", {dq_drive, dq_out}, {1'b1, 8'hC0});
        idle();
        busy_read(1'b0, 1'b0, "R9 next access after coincident");
        wr_busy = 1'b0;
        idle();

        // R9 case B: busy rise in the middle of a running access
        arr_data = 8'h3C; last_byte = 8'h80;
        ce_n = 1'b0; oe_n = 1'b0;
        step();
        chk("R9 pre-rise data", {dq_drive, dq_out}, {1'b1, 8'h3C});
        wr_busy = 1'b1;
        step();
        chk("R9 mid-access rise", {dq_drive, dq_out}, {1'b1, 8'h40});
        idle();
        busy_read(1'b1, 1'b0, "R9 next access after mid rise");
        busy_read(1'b0, 1'b1, "R5 third access");
        wr_busy = 1'b0;
        idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule